// File: doc/BRIEF.md
# Vectorised Branch Condition Evaluator

This block decides one vector-aware conditional branch. When `start` is pulsed while it is idle or finished, it walks the elements 0 to `vl`-1, one per clock, testing one bit of each element's 4-bit condition field against the branch options. The element results are folded into a single decision by an AND or an OR reduction. Testing can stop early, and the vector length can be cut short. A counter-only test mode gives the CTR register its own per-element rules. Once the decision is known, the unit produces the next instruction address and the new CTR, link register and vector length, then raises `done`.

The surrounding pipeline presents the condition fields of all elements, the predicate mask, the branch option bits and the mode bits, and holds them stable from `start` until `done`. The results stay on the outputs, unchanged, for as long as `done` is high. The next accepted `start` begins another evaluation. Fetching the condition fields and decoding the instruction are done elsewhere.

Top module: `vec_branch_unit`

## Requirements
- R1: After reset `done` is 0 and every result output is 0. A `start` seen while idle or done loads the inputs. With no early stop, `done` rises on the (`vl`+2)-th rising edge counting the edge that took `start`. A `start` during an evaluation is ignored. While `done` is high and `start` is low, every output holds its value even when the inputs change.
- R2: Element i uses the nibble `crFields[4i+3:4i]`. Field bit 0 is the nibble's MSB, and `biLow` selects field bit `biLow`, which is nibble bit 3-`biLow`. The element passes when `boIgnoreCond` is 1 or the selected bit equals `boCondSense`.
- R3: The element result is (pass AND ctrOk). The accumulated decision starts equal to `modeAll`. It is the AND of the results when `modeAll`=1 and the OR when `modeAll`=0. So with `vl`=0 an ALL branch is taken and an OR branch is not.
- R4: Evaluation stops after the first tested element whose result differs from `modeAll`. Later elements have no effect, including on CTR.
- R5: For a tested element, CTR is decremented when `boNoCtr`=0, unless `modeCtrTest`=1 and (pass XOR `modeCtrInv`)=1. ctrOk is 1 when `boNoCtr`=1, or when ((CTR after this element's decrement) != 0) XOR `boCtrZero`.
- R6: An element whose predicate bit is 0 is skipped when `modeSz`=0. It then decrements CTR only if `boNoCtr`=0, `modeCtrTest`=1 and `modeCtrInv`=0, and it leaves the decision unchanged. When `modeSz`=1 it is tested with `modeSnz` as its selected bit.
- R7: With `modeVlSet`=1, the first tested element whose result equals `modeVsb` stops evaluation and sets `vlOut` to srcstep+1 if `modeVli`=1, or to srcstep otherwise. Without such an element `vlOut` equals `vl`.
- R8: With `crScalar`=1, evaluation ends after element 0.
- R9: A taken branch yields `nia` = sign-extended {`bd`,00} when `aa`=1, or `cia` plus that value when `aa`=0. A branch not taken yields `cia`+4.
- R10: `lrOut` is `cia`+4 when it is written and `lrIn` otherwise. It is written: never for `lk`=0,`modeLru`=0; always for `lk`=1,`modeLru`=0; only on failure for `lk`=1,`modeLru`=1; only on success for `lk`=0,`modeLru`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an evaluation (taken when not busy) |
| vl | input | VLW | Vector length, at most MAXVL |
| crFields | input | 4*MAXVL | Condition field of each element, element i in nibble i |
| predMask | input | MAXVL | Predicate bit per element |
| crScalar | input | 1 | Condition fields come from a scalar register |
| boIgnoreCond | input | 1 | Branch option: ignore the condition bit |
| boCondSense | input | 1 | Branch option: required value of the tested bit |
| boNoCtr | input | 1 | Branch option: leave CTR alone |
| boCtrZero | input | 1 | Branch option: branch on CTR reaching zero |
| biLow | input | 2 | Selects the tested bit inside a field |
| modeAll | input | 1 | AND reduction (1) or OR reduction (0) |
| modeSnz | input | 1 | Tested bit for masked elements when modeSz=1 |
| modeSz | input | 1 | Test masked elements instead of skipping them |
| modeCtrTest | input | 1 | Counter-test mode |
| modeCtrInv | input | 1 | Invert the counter-test decrement condition |
| modeVlSet | input | 1 | Vector-length truncation mode |
| modeVsb | input | 1 | Element result that triggers truncation |
| modeVli | input | 1 | Truncated length includes the current element |
| modeLru | input | 1 | Conditional link-register update |
| lk | input | 1 | Link bit |
| aa | input | 1 | Absolute target address |
| bd | input | BDW | Branch displacement in words |
| cia | input | AW | Current instruction address |
| ctrIn | input | CW | CTR value at start |
| lrIn | input | AW | Link register value at start |
| done | output | 1 | Results valid and held |
| nia | output | AW | Next instruction address |
| ctrOut | output | CW | Updated CTR |
| lrOut | output | AW | Updated link register |
| vlOut | output | VLW | Updated vector length |

## Verification
The bench targets early exit. A design that kept testing past the deciding element would decrement CTR too often or flip the decision, and the counter-exhaustion and CTR-test vectors expose that through `ctrOut`. It also probes the empty vector (ALL taken, OR not taken), masked elements in both zeroing settings, truncation with and without the current element, the scalar-field stop, and a negative displacement, where a missing sign extension sends the branch forward. All four link-register combinations are driven, so a design that simply writes LR whenever `lk` is set, or ignores `modeLru`, gives the wrong `lrOut`.

// File: rtl/vbr_pkg.sv
package vbr_pkg;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } vbrStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } vbrState_t;

endpackage

// File: rtl/vbr_ctrl.sv
module vbr_ctrl
  import vbr_pkg::*;
#(
  parameter int MAXVL = 8,
  localparam int VLW = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [VLW-1:0]   vl,
  input  logic             stopFlag,
  output vbrStrobe_t       strobe,
  output logic [VLW-1:0]   idx,
  output logic             done
);

  vbrState_t state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          strobe.load = 1'b1;
          nextState   = ST_RUN;
        end
      end
      ST_RUN: begin
        if (idx == vl || stopFlag) begin
          strobe.finish = 1'b1;
          nextState     = ST_DONE;
        end else begin
          strobe.step = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      state <= nextState;
      if (strobe.load) idx <= '0;
      else if (strobe.step) idx <= idx + 1'b1;
    end
  end

  assign done = (state == ST_DONE);

endmodule

// File: rtl/vbr_datapath.sv
module vbr_datapath
  import vbr_pkg::*;
#(
  parameter int MAXVL = 8,
  parameter int AW    = 32,
  parameter int CW    = 32,
  parameter int BDW   = 14,
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int PADN = 1 << VLW
) (
  input  logic               clk,
  input  logic               rstN,
  input  vbrStrobe_t         strobe,
  input  logic [VLW-1:0]     idx,
  input  logic [VLW-1:0]     vl,
  input  logic [4*MAXVL-1:0] crFields,
  input  logic [MAXVL-1:0]   predMask,
  input  logic               crScalar,
  input  logic               boIgnoreCond,
  input  logic               boCondSense,
  input  logic               boNoCtr,
  input  logic               boCtrZero,
  input  logic [1:0]         biLow,
  input  logic               modeAll,
  input  logic               modeSnz,
  input  logic               modeSz,
  input  logic               modeCtrTest,
  input  logic               modeCtrInv,
  input  logic               modeVlSet,
  input  logic               modeVsb,
  input  logic               modeVli,
  input  logic               modeLru,
  input  logic               lk,
  input  logic               aa,
  input  logic [BDW-1:0]     bd,
  input  logic [AW-1:0]      cia,
  input  logic [CW-1:0]      ctrIn,
  input  logic [AW-1:0]      lrIn,
  output logic               stopFlag,
  output logic [AW-1:0]      nia,
  output logic [CW-1:0]      ctrOut,
  output logic [AW-1:0]      lrOut,
  output logic [VLW-1:0]     vlOut
);

  // padded copies so that any idx value selects a defined element
  logic [4*PADN-1:0] crPad;
  logic [PADN-1:0]   predPad;
  assign crPad   = {{(4*(PADN-MAXVL)){1'b0}}, crFields};
  assign predPad = {{(PADN-MAXVL){1'b0}}, predMask};

  logic [CW-1:0]  ctrReg;
  logic           accReg;
  logic [VLW-1:0] vlReg;
  logic           stopReg;
  logic [AW-1:0]  niaReg, lrReg;

  logic [3:0]    field;
  logic          predBit, maskedSkip, testBit, elPass;
  logic          doDec, ctrOk, elRes, accNext, vlHit, stopNext;
  logic [CW-1:0] ctrNext;
  logic [AW-1:0] dispExt, linkAddr;
  logic          lrWrite;

  always_comb begin
    field      = crPad[{idx, 2'b00} +: 4];
    predBit    = predPad[idx];
    maskedSkip = !predBit && !modeSz;
    testBit    = predBit ? field[~biLow] : modeSnz;
    elPass     = boIgnoreCond || (testBit == boCondSense);
    if (maskedSkip)
      doDec = !boNoCtr && modeCtrTest && !modeCtrInv;
    else
      doDec = !boNoCtr && !(modeCtrTest && (elPass ^ modeCtrInv));
    ctrNext  = doDec ? ctrReg - 1'b1 : ctrReg;
    ctrOk    = boNoCtr || ((ctrNext != '0) ^ boCtrZero);
    elRes    = elPass && ctrOk;
    accNext  = modeAll ? (accReg && elRes) : (accReg || elRes);
    vlHit    = !maskedSkip && modeVlSet && (modeVsb == elRes);
    stopNext = crScalar || vlHit || (!maskedSkip && (modeAll != elRes));
  end

  assign dispExt  = {{(AW-BDW-2){bd[BDW-1]}}, bd, 2'b00};
  assign linkAddr = cia + AW'(4);
  assign lrWrite  = lk ^ (accReg && modeLru);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrReg  <= '0;
      accReg  <= 1'b0;
      vlReg   <= '0;
      stopReg <= 1'b0;
      niaReg  <= '0;
      lrReg   <= '0;
    end else begin
      if (strobe.load) begin
        ctrReg  <= ctrIn;
        accReg  <= modeAll;
        vlReg   <= vl;
        stopReg <= 1'b0;
      end
      if (strobe.step) begin
        ctrReg  <= ctrNext;
        stopReg <= stopNext;
        if (!maskedSkip) accReg <= accNext;
        if (vlHit) vlReg <= modeVli ? idx + 1'b1 : idx;
      end
      if (strobe.finish) begin
        if (accReg) niaReg <= aa ? dispExt : cia + dispExt;
        else        niaReg <= linkAddr;
        lrReg <= lrWrite ? linkAddr : lrIn;
      end
    end
  end

  assign stopFlag = stopReg;
  assign nia      = niaReg;
  assign ctrOut   = ctrReg;
  assign lrOut    = lrReg;
  assign vlOut    = vlReg;

endmodule

// File: rtl/vec_branch_unit.sv
module vec_branch_unit
  import vbr_pkg::*;
#(
  parameter int MAXVL = 8,
  parameter int AW    = 32,
  parameter int CW    = 32,
  parameter int BDW   = 14,
  localparam int VLW  = $clog2(MAXVL + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [VLW-1:0]     vl,
  input  logic [4*MAXVL-1:0] crFields,
  input  logic [MAXVL-1:0]   predMask,
  input  logic               crScalar,
  input  logic               boIgnoreCond,
  input  logic               boCondSense,
  input  logic               boNoCtr,
  input  logic               boCtrZero,
  input  logic [1:0]         biLow,
  input  logic               modeAll,
  input  logic               modeSnz,
  input  logic               modeSz,
  input  logic               modeCtrTest,
  input  logic               modeCtrInv,
  input  logic               modeVlSet,
  input  logic               modeVsb,
  input  logic               modeVli,
  input  logic               modeLru,
  input  logic               lk,
  input  logic               aa,
  input  logic [BDW-1:0]     bd,
  input  logic [AW-1:0]      cia,
  input  logic [CW-1:0]      ctrIn,
  input  logic [AW-1:0]      lrIn,
  output logic               done,
  output logic [AW-1:0]      nia,
  output logic [CW-1:0]      ctrOut,
  output logic [AW-1:0]      lrOut,
  output logic [VLW-1:0]     vlOut
);

  vbrStrobe_t     strobe;
  logic [VLW-1:0] idx;
  logic           stopFlag;

  vbr_ctrl #(.MAXVL(MAXVL)) ctrl (
    .clk(clk), .rstN(rstN), .start(start), .vl(vl), .stopFlag(stopFlag),
    .strobe(strobe), .idx(idx), .done(done)
  );

  vbr_datapath #(.MAXVL(MAXVL), .AW(AW), .CW(CW), .BDW(BDW)) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .idx(idx), .vl(vl),
    .crFields(crFields), .predMask(predMask), .crScalar(crScalar),
    .boIgnoreCond(boIgnoreCond), .boCondSense(boCondSense),
    .boNoCtr(boNoCtr), .boCtrZero(boCtrZero), .biLow(biLow),
    .modeAll(modeAll), .modeSnz(modeSnz), .modeSz(modeSz),
    .modeCtrTest(modeCtrTest), .modeCtrInv(modeCtrInv),
    .modeVlSet(modeVlSet), .modeVsb(modeVsb), .modeVli(modeVli),
    .modeLru(modeLru), .lk(lk), .aa(aa), .bd(bd), .cia(cia),
    .ctrIn(ctrIn), .lrIn(lrIn), .stopFlag(stopFlag),
    .nia(nia), .ctrOut(ctrOut), .lrOut(lrOut), .vlOut(vlOut)
  );

endmodule

// File: rtl/vbr_checker.sv
module vbr_checker #(
  parameter int MAXVL = 8,
  parameter int AW    = 32,
  parameter int CW    = 32,
  localparam int VLW  = $clog2(MAXVL + 1)
) (
  input logic           clk,
  input logic           rstN,
  input logic           start,
  input logic           done,
  input logic [VLW-1:0] vl,
  input logic [AW-1:0]  nia,
  input logic [CW-1:0]  ctrOut,
  input logic [AW-1:0]  lrOut,
  input logic [VLW-1:0] vlOut,
  input logic           load,
  input logic           step,
  input logic           finish
);

  logic [VLW-1:0] latchedVl;
  logic [VLW-1:0] stepCount;
  logic           busyFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchedVl <= '0;
      stepCount <= '0;
      busyFlag  <= 1'b0;
    end else begin
      if (load) begin
        latchedVl <= vl;
        stepCount <= '0;
        busyFlag  <= 1'b1;
      end
      if (step) stepCount <= stepCount + 1'b1;
      if (finish) busyFlag <= 1'b0;
    end
  end

  // R1: results are frozen while done is held
  a_r1_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done && $stable(nia) && $stable(lrOut)
                       && $stable(ctrOut) && $stable(vlOut));

  // R1: a start during an evaluation does not reload
  a_r1_busy_ignores_start: assert property (@(posedge clk) disable iff (!rstN)
    busyFlag |-> !load);

  // R1: control issues at most one action per cycle
  a_r1_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({load, step, finish}));

  // R4: never more elements stepped than the vector length
  a_r4_steps_bounded: assert property (@(posedge clk) disable iff (!rstN)
    step |-> stepCount < latchedVl);

  // R5: an element changes CTR by at most one
  a_r5_ctr_single_dec: assert property (@(posedge clk) disable iff (!rstN)
    step |=> (ctrOut == $past(ctrOut)) || (ctrOut == $past(ctrOut) - 1'b1));

  // R7: the vector length can only shrink
  a_r7_vl_not_grown: assert property (@(posedge clk) disable iff (!rstN)
    done |-> vlOut <= latchedVl);

endmodule

bind vec_branch_unit vbr_checker #(.MAXVL(MAXVL), .AW(AW), .CW(CW)) chk (
  .clk(clk), .rstN(rstN), .start(start), .done(done), .vl(vl),
  .nia(nia), .ctrOut(ctrOut), .lrOut(lrOut), .vlOut(vlOut),
  .load(strobe.load), .step(strobe.step), .finish(strobe.finish)
);

// File: tb/vec_branch_unit_test.sv
`timescale 1ns/1ps
module vec_branch_unit_test;

  localparam int MAXVL = 8;
  localparam int AW = 32;
  localparam int CW = 32;
  localparam int BDW = 14;
  localparam int VLW = $clog2(MAXVL + 1);
  localparam logic [AW-1:0] LR_INIT = 32'hAAAA0000;
  localparam logic [AW-1:0] CIA0 = 32'h00001000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [VLW-1:0] vl = '0;
  logic [4*MAXVL-1:0] crFields = '0;
  logic [MAXVL-1:0] predMask = '0;
  logic crScalar = 0, boIgnoreCond = 0, boCondSense = 0, boNoCtr = 0, boCtrZero = 0;
  logic [1:0] biLow = '0;
  logic modeAll = 0, modeSnz = 0, modeSz = 0, modeCtrTest = 0, modeCtrInv = 0;
  logic modeVlSet = 0, modeVsb = 0, modeVli = 0, modeLru = 0, lk = 0, aa = 0;
  logic [BDW-1:0] bd = '0;
  logic [AW-1:0] cia = CIA0;
  logic [CW-1:0] ctrIn = '0;
  logic [AW-1:0] lrIn = LR_INIT;
  logic done;
  logic [AW-1:0] nia, lrOut;
  logic [CW-1:0] ctrOut;
  logic [VLW-1:0] vlOut;

  always #10 clk = ~clk;

  vec_branch_unit #(.MAXVL(MAXVL), .AW(AW), .CW(CW), .BDW(BDW)) uut (
    .clk(clk), .rstN(rstN), .start(start), .vl(vl), .crFields(crFields),
    .predMask(predMask), .crScalar(crScalar), .boIgnoreCond(boIgnoreCond),
    .boCondSense(boCondSense), .boNoCtr(boNoCtr), .boCtrZero(boCtrZero),
    .biLow(biLow), .modeAll(modeAll), .modeSnz(modeSnz), .modeSz(modeSz),
    .modeCtrTest(modeCtrTest), .modeCtrInv(modeCtrInv), .modeVlSet(modeVlSet),
    .modeVsb(modeVsb), .modeVli(modeVli), .modeLru(modeLru), .lk(lk), .aa(aa),
    .bd(bd), .cia(cia), .ctrIn(ctrIn), .lrIn(lrIn), .done(done), .nia(nia),
    .ctrOut(ctrOut), .lrOut(lrOut), .vlOut(vlOut)
  );

  // flags: {crScalar,boIgnoreCond,boCondSense,boNoCtr,boCtrZero}_{biLow}_
  //        {modeAll,modeSnz,modeSz,modeCtrTest,modeCtrInv}_{modeVlSet,modeVsb,modeVli}_{modeLru,lk,aa}
  typedef struct packed {
    logic [3:0]  vlen;
    logic [15:0] cr;
    logic [3:0]  pred;
    logic [17:0] flags;
    logic [13:0] disp;
    logic [7:0]  ctr;
    logic [15:0] eNia;
    logic [7:0]  eCtr;
    logic        eLrW;
    logic [3:0]  eVl;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    // R3 OR, early hit on element 1; R10 lk=1 lru=0 writes
    '{4'd4, 16'h2020, 4'hF, 18'b00110_10_00000_000_010, 14'h10, 8'd10, 16'h1040, 8'd10, 1'b1, 4'd4, 4'd3},
    // R4 ALL fails on element 0; lk=0 lru=1 fail: no write
    '{4'd4, 16'h2020, 4'hF, 18'b00110_10_10000_000_100, 14'h10, 8'd10, 16'h1004, 8'd10, 1'b0, 4'd4, 4'd4},
    // R10 ALL taken, lk=1 lru=1 no write; R9 absolute
    '{4'd4, 16'h2222, 4'hF, 18'b00110_10_10000_000_111, 14'h10, 8'd10, 16'h0040, 8'd10, 1'b0, 4'd4, 4'd10},
    // R10 OR fails, lk=1 lru=1 writes
    '{4'd4, 16'h0000, 4'hF, 18'b00110_10_00000_000_110, 14'h10, 8'd10, 16'h1004, 8'd10, 1'b1, 4'd4, 4'd10},
    // R5 decrement per element
    '{4'd4, 16'h2222, 4'hF, 18'b00100_10_10000_000_000, 14'h10, 8'd10, 16'h1040, 8'd6, 1'b0, 4'd4, 4'd5},
    // R5 CTR exhausted on element 1
    '{4'd4, 16'h2222, 4'hF, 18'b00100_10_10000_000_000, 14'h10, 8'd2, 16'h1004, 8'd0, 1'b0, 4'd4, 4'd5},
    // R5 CTR-test decrements only failing elements
    '{4'd4, 16'h0200, 4'hF, 18'b00100_10_00010_000_000, 14'h10, 8'd10, 16'h1040, 8'd8, 1'b0, 4'd4, 4'd5},
    // R7 truncate on success, exclusive
    '{4'd4, 16'h0200, 4'hF, 18'b00110_10_00000_110_000, 14'h10, 8'd10, 16'h1040, 8'd10, 1'b0, 4'd2, 4'd7},
    // R7 truncate on failure, inclusive
    '{4'd4, 16'h2022, 4'hF, 18'b00110_10_10000_101_000, 14'h10, 8'd10, 16'h1004, 8'd10, 1'b0, 4'd3, 4'd7},
    // R6 masked skipped with CTR-test decrement
    '{4'd4, 16'h2222, 4'hD, 18'b00100_10_10010_000_000, 14'h10, 8'd10, 16'h1040, 8'd9, 1'b0, 4'd4, 4'd6},
    // R6 sz=1 snz=0 masked element fails
    '{4'd4, 16'h2222, 4'hD, 18'b00110_10_10100_000_000, 14'h10, 8'd10, 16'h1004, 8'd10, 1'b0, 4'd4, 4'd6},
    // R8 scalar stops after element 0
    '{4'd4, 16'h2220, 4'hF, 18'b10110_10_00000_000_000, 14'h10, 8'd10, 16'h1004, 8'd10, 1'b0, 4'd4, 4'd8},
    // R3 vl=0 ALL taken
    '{4'd0, 16'h0000, 4'hF, 18'b00110_10_10000_000_000, 14'h10, 8'd10, 16'h1040, 8'd10, 1'b0, 4'd0, 4'd3},
    // R3 vl=0 OR fails
    '{4'd0, 16'h0000, 4'hF, 18'b00110_10_00000_000_000, 14'h10, 8'd10, 16'h1004, 8'd10, 1'b0, 4'd0, 4'd3},
    // R2 ignore-condition option
    '{4'd3, 16'h0000, 4'hF, 18'b01110_10_00000_000_000, 14'h10, 8'd10, 16'h1040, 8'd10, 1'b0, 4'd3, 4'd2},
    // R2 biLow=0 selects nibble MSB
    '{4'd4, 16'h0008, 4'hF, 18'b00110_00_00000_000_000, 14'h10, 8'd10, 16'h1040, 8'd10, 1'b0, 4'd4, 4'd2},
    // R2 sense=0 against set bits fails
    '{4'd4, 16'h2222, 4'hF, 18'b00010_10_00000_000_000, 14'h10, 8'd10, 16'h1004, 8'd10, 1'b0, 4'd4, 4'd2},
    // R9 negative displacement
    '{4'd0, 16'h0000, 4'hF, 18'b00110_10_10000_000_000, 14'h3FFF, 8'd10, 16'h0FFC, 8'd10, 1'b0, 4'd0, 4'd9},
    // R5 branch on CTR reaching zero
    '{4'd4, 16'h2222, 4'hF, 18'b00101_10_00000_000_000, 14'h10, 8'd3, 16'h1040, 8'd0, 1'b0, 4'd4, 4'd5},
    // R10 lk=0 lru=1 taken writes
    '{4'd4, 16'h2020, 4'hF, 18'b00110_10_00000_000_100, 14'h10, 8'd10, 16'h1040, 8'd10, 1'b1, 4'd4, 4'd10},
    // R6 sz=1 snz=1 masked element passes
    '{4'd4, 16'h2222, 4'hD, 18'b00110_10_11100_000_000, 14'h10, 8'd10, 16'h1040, 8'd10, 1'b0, 4'd4, 4'd6}
  };

  int checks = 0;
  int failures = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic applyVec(input vec_t v);
    crFields = {16'h0, v.cr};
    predMask = {4'hF, v.pred};
    vl = v.vlen;
    {crScalar, boIgnoreCond, boCondSense, boNoCtr, boCtrZero} = v.flags[17:13];
    biLow = v.flags[12:11];
    {modeAll, modeSnz, modeSz, modeCtrTest, modeCtrInv} = v.flags[10:6];
    {modeVlSet, modeVsb, modeVli} = v.flags[5:3];
    {modeLru, lk, aa} = v.flags[2:0];
    bd = v.disp;
    ctrIn = {24'h0, v.ctr};
    cia = CIA0;
    lrIn = LR_INIT;
  endtask

  task automatic waitDone(output int n);
    n = 0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    string rq;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "reset done", {31'h0, done}, 32'h0);
    check("R1", "reset nia", nia, 32'h0);
    check("R1", "reset ctr", ctrOut, 32'h0);
    check("R1", "reset lr", lrOut, 32'h0);
    check("R1", "reset vl", {28'h0, vlOut}, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      applyVec(VECS[i]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      waitDone(n);
      rq = $sformatf("R%0d", VECS[i].req);
      check(rq, $sformatf("vec%0d done", i), {31'h0, done}, 32'h1);
      check(rq, $sformatf("vec%0d nia", i), nia, {16'h0, VECS[i].eNia});
      check(rq, $sformatf("vec%0d ctr", i), ctrOut, {24'h0, VECS[i].eCtr});
      check(rq, $sformatf("vec%0d lr", i), lrOut, VECS[i].eLrW ? CIA0 + 32'd4 : LR_INIT);
      check(rq, $sformatf("vec%0d vl", i), {28'h0, vlOut}, {28'h0, VECS[i].eVl});
    end

    // R1 timing with a start pulse during the evaluation (ALL, 4 passing elements)
    applyVec(VECS[2]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    for (int k = 1; k <= 5; k++) begin
      if (k == 2) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (k < 5) check("R1", $sformatf("done low after %0d edges", k), {31'h0, done}, 32'h0);
    end
    check("R1", "done at vl+2 edges", {31'h0, done}, 32'h1);
    check("R1", "nia after ignored start", nia, 32'h40);

    // R1 hold: inputs change while done, outputs do not
    cia = 32'h00002000;
    lrIn = 32'h12345678;
    ctrIn = 32'd99;
    vl = 4'd1;
    repeat (3) @(negedge clk);
    check("R1", "hold done", {31'h0, done}, 32'h1);
    check("R1", "hold nia", nia, 32'h40);
    check("R1", "hold lr", lrOut, LR_INIT);
    check("R1", "hold ctr", ctrOut, 32'd10);
    check("R1", "hold vl", {28'h0, vlOut}, 32'd4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule